// File: doc/BRIEF.md
# Iterative Logical Right Shifter

This block shifts a data word right by a variable amount, one bit position per clock, filling the vacated upper bits with zeros. The amount is taken from a small constant field that arrives with the request. When that field is zero, the amount is taken instead from the low bits of a register-supplied value. A down-counter holds the remaining amount: it can be loaded, it counts down by one on each shift, and a zero test on it decides when the shifting stops.

A request is a one-cycle `start` while the block is idle. The block captures its operands on that edge, settles the amount in a second cycle, copies the data into the result register in a third, then shifts once per cycle until the counter is empty. A one-cycle `done` pulse marks the result as final. The result stays in place until the next request is accepted, so a later stage can write it back at its own pace.

Top module: `serial_srl_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls with no request, `busy` is 0, `done` is 0 and `result` is all zeros.
- R2: When the constant field `imm_cnt` is nonzero, the shift amount equals `imm_cnt` and the value on `reg_cnt` has no effect on the result.
- R3: When `imm_cnt` is zero, the shift amount equals `reg_cnt` (the low bits of the register operand).
- R4: The final `result` equals the captured data shifted right by the amount, with a 0 entering the top bit at every step.
- R5: If `start` is accepted on a rising edge (counted as edge 1), `done` is high for the cycle after edge n+4, where n is the amount; `busy` is high from the cycle after edge 1 until `done` rises, and falls together with it.
- R6: When both `imm_cnt` and `reg_cnt` are zero, `result` equals the captured data unchanged and `done` follows after edge 4 with no shift cycles.
- R7: A `start` that arrives while `busy` is high is ignored: the operands, result and timing of the running request are unchanged.
- R8: `done` lasts exactly one cycle, and `result` keeps its value while the block is idle until another `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a shift; accepted only when idle |
| imm_cnt | input | CNT_W (5) | Constant amount field from the instruction |
| reg_cnt | input | CNT_W (5) | Low bits of the register operand, used when `imm_cnt` is zero |
| data_in | input | DATA_W (32) | Value to shift |
| result | output | DATA_W (32) | Shifted value, final when `done` pulses |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when `result` is final |

## Verification
The bench builds the block with its defaults, a 32-bit word and therefore a 5-bit counter, so every amount from 0 to 31 is reachable, including the longest run of 31 shift cycles and the all-zero fallback. With this width the extreme cases a wider word would hide, such as a single top bit walking to bit 0 and a full-ones word shrinking to one bit, are observed directly at the `result` port, together with the exact cycle of `done` for each amount.

// File: rtl/srl_seq_pkg.sv
package srl_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIX   = 2'd1,
    ST_COPY  = 2'd2,
    ST_SHIFT = 2'd3
  } srl_state_e;

endpackage

// File: rtl/srl_count.sv
module srl_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_imm,
  input  logic [CNT_W-1:0] imm_val,
  input  logic             ld_alt,
  input  logic [CNT_W-1:0] alt_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             is_zero
);

  assign is_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_imm) begin
      cnt_q <= imm_val;
    end else if (ld_alt) begin
      cnt_q <= alt_val;
    end else if (dec && !is_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: each shift step removes exactly one from the remaining amount
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (dec && !is_zero && !ld_imm && !ld_alt) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: fallback load takes the register-supplied amount
  a_r3_alt_load: assert property (@(posedge clk) disable iff (rst)
    (ld_alt && !ld_imm) |=> (cnt_q == $past(alt_val)));

endmodule

// File: rtl/srl_shreg.sv
module srl_shreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              shift,
  output logic [DATA_W-1:0] res_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (ld) begin
      res_q <= ld_val;
    end else if (shift) begin
      res_q <= {1'b0, res_q[DATA_W-1:1]};
    end
  end

  // R4: a shift step brings in a zero at the top and moves every bit down one
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (shift && !ld) |=> (res_q[DATA_W-1] == 1'b0) &&
                       (res_q[DATA_W-2:0] == $past(res_q[DATA_W-1:1])));

endmodule

// File: rtl/srl_ctrl.sv
module srl_ctrl
  import srl_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cnt_zero,
  output logic ld_imm,
  output logic ld_alt,
  output logic ld_res,
  output logic shift_en,
  output logic busy_q,
  output logic done_q
);

  srl_state_e state_q;

  assign ld_imm   = (state_q == ST_IDLE) && start;
  assign ld_alt   = (state_q == ST_FIX) && cnt_zero;
  assign ld_res   = (state_q == ST_COPY);
  assign shift_en = (state_q == ST_SHIFT) && !cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FIX;
            busy_q  <= 1'b1;
          end
        end
        ST_FIX:  state_q <= ST_COPY;
        ST_COPY: state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is reported for a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5: busy falls on the same edge that raises done
  a_r5_busy_clear: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R7: setup steps always advance, whatever start does
  a_r7_fix_advance: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIX) |=> (state_q == ST_COPY));

  a_r7_copy_advance: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COPY) |=> (state_q == ST_SHIFT));

  // R5: busy flag tracks the sequencer being active
  a_r5_busy_state: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (state_q != ST_IDLE));

endmodule

// File: rtl/serial_srl_unit.sv
module serial_srl_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  imm_cnt,
  input  logic [CNT_W-1:0]  reg_cnt,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              done
);

  logic              ld_imm;
  logic              ld_alt;
  logic              ld_res;
  logic              shift_en;
  logic              cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  logic [CNT_W-1:0]  alt_q;
  logic [DATA_W-1:0] data_q;

  // operands are captured on the accepting edge so the caller may move on
  always_ff @(posedge clk) begin
    if (rst) begin
      alt_q  <= '0;
      data_q <= '0;
    end else if (ld_imm) begin
      alt_q  <= reg_cnt;
      data_q <= data_in;
    end
  end

  srl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cnt_zero (cnt_zero),
    .ld_imm   (ld_imm),
    .ld_alt   (ld_alt),
    .ld_res   (ld_res),
    .shift_en (shift_en),
    .busy_q   (busy),
    .done_q   (done)
  );

  srl_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .ld_imm  (ld_imm),
    .imm_val (imm_cnt),
    .ld_alt  (ld_alt),
    .alt_val (alt_q),
    .dec     (shift_en),
    .cnt_q   (cnt_val),
    .is_zero (cnt_zero)
  );

  srl_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld_res),
    .ld_val (data_q),
    .shift  (shift_en),
    .res_q  (result)
  );

  // R8: an idle block leaves its result alone
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  // R7: operands do not move while a request runs
  a_r7_operands_kept: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(data_q) && $stable(alt_q));

  // R2: a nonzero constant field is what the counter holds after loading
  a_r2_imm_load: assert property (@(posedge clk) disable iff (rst)
    (ld_imm && imm_cnt != '0) |=> (cnt_val == $past(imm_cnt)));

endmodule

// File: tb/serial_srl_unit_tb.sv
module serial_srl_unit_tb;

  localparam int DW = 32;
  localparam int CW = 5;
  localparam int NVEC = 8;

  // {imm, reg count, data}
  localparam logic [CW+CW+DW-1:0] VEC [NVEC] = '{
    {5'd1,  5'd0,  32'h8000_0000},
    {5'd31, 5'd7,  32'hFFFF_FFFF},
    {5'd0,  5'd4,  32'h1234_5678},
    {5'd0,  5'd3,  32'hF0F0_F0F0},
    {5'd0,  5'd0,  32'hDEAD_BEEF},
    {5'd16, 5'd5,  32'hA5A5_0000},
    {5'd0,  5'd31, 32'h8000_0001},
    {5'd8,  5'd0,  32'hCAFE_BABE}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] imm_i = '0;
  logic [CW-1:0] rc_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] result;
  logic          busy;
  logic          done;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  serial_srl_unit u_dut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .imm_cnt (imm_i),
    .reg_cnt (rc_i),
    .data_in (data_i),
    .result  (result),
    .busy    (busy),
    .done    (done)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one request and count edges (start edge = 1) until done is seen
  task automatic run_op(input logic [CW-1:0] imm, input logic [CW-1:0] rc,
                        input logic [DW-1:0] d, output int lat, output logic busy_seen);
    @(negedge clk);
    imm_i = imm; rc_i = rc; data_i = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    imm_i = ~imm; rc_i = ~rc; data_i = ~d;
    busy_seen = busy;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic bz;
    logic [DW-1:0] held;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", {31'd0, busy}, 32'd0);
    check("R1", "done in reset", {31'd0, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "result after reset", result, 32'd0);
    check("R1", "busy after reset", {31'd0, busy}, 32'd0);

    // table walk: R2/R3/R4/R6 result, R5 timing
    for (int i = 0; i < NVEC; i++) begin
      logic [CW-1:0] vi, vr;
      logic [DW-1:0] vd;
      int n;
      {vi, vr, vd} = VEC[i];
      n = (vi != 0) ? int'(vi) : int'(vr);
      run_op(vi, vr, vd, lat, bz);
      if (vi != 0)      check("R2", "result imm amount", result, vd >> n);
      else if (vr != 0) check("R3", "result reg amount", result, vd >> n);
      else              check("R6", "result zero amount", result, vd);
      check("R4", "zero-filled shift", result, vd >> n);
      check("R5", "done edge", lat, n + 4);
      check("R5", "busy after start", {31'd0, bz}, 32'd1);
      check("R5", "busy low with done", {31'd0, busy}, 32'd0);
    end

    // R8: single-cycle done, result held while idle
    held = result;
    @(negedge clk);
    check("R8", "done one cycle", {31'd0, done}, 32'd0);
    data_i = 32'h5555_5555; imm_i = 5'd3;
    repeat (3) @(negedge clk);
    check("R8", "result held idle", result, held);

    // R7: second start while busy is ignored
    @(negedge clk);
    imm_i = 5'd2; rc_i = 5'd9; data_i = 32'h0000_F000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    imm_i = 5'd1; rc_i = 5'd0; data_i = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R7", "result of first request", result, 32'h0000_3C00);
    check("R7", "timing of first request", lat, 6);
    @(negedge clk);
    check("R7", "no second run", {31'd0, busy}, 32'd0);

    // R6 directed: zero amount from both sources finishes on edge 4
    run_op(5'd0, 5'd0, 32'h0000_0001, lat, bz);
    check("R6", "zero amount latency", lat, 4);
    check("R6", "zero amount value", result, 32'h0000_0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule